// File: doc/BRIEF.md
# Single-to-Double Float Format Converter

This block widens a 32-bit IEEE-754 single-precision word into the 64-bit double-precision image that a floating-point register file holds. Normal numbers, signed zeros, infinities and NaNs are mapped by a purely combinational bit rearrangement. The exponent is widened by replicating the top exponent bit, inverted for normal numbers and copied for specials, and the fraction is padded with zeros. The result is registered one cycle after acceptance.

Subnormal single-precision inputs have no hidden one, so they cannot be copied across. They are normalized by a small sequential shifter. It starts from an exponent of -126 and shifts the significand left one bit per clock, decrementing the exponent, until the leading one reaches the hidden-bit position. The result is then rebiased for the double format.

The input side is a valid/ready handshake. While a subnormal is being normalized, ready is low. The output side is a held valid flag with a one-cycle done strobe on each new result.

Top module: `sgl2dbl_conv`

## Requirements
- R1: Bit layout is as follows. Input bit 31 is the sign, bits 30:23 the exponent e and bits 22:0 the fraction f. Output bit 63 is the sign, bits 62:52 the exponent and bits 51:0 the fraction. For 1 <= e <= 254, the output carries the same sign, exponent field e+896 and fraction f followed by 29 zero bits.
- R2: For e = 255, or for e = 0 with f = 0, the output carries the same sign and the fraction f followed by 29 zeros. The exponent field is 2047 for e = 255 and 0 for a zero input.
- R3: For e = 0 and f != 0, let p be the index of the highest set bit of f and k = 23 - p. The output carries the same sign and exponent field 897 - k. Its fraction is the bits of f below bit p, left-aligned to output bit 51, followed by zeros.
- R4: A normal, zero, infinity or NaN input accepted at a clock edge gives outValid = 1, outDone = 1 and the result right after that edge.
- R5: A subnormal input accepted at a clock edge gives its result, with outDone, k + 1 edges after acceptance. This is never more than 24 edges.
- R6: From the edge that accepts a subnormal until its result appears, inReady is 0 and outValid is 0. inWord and inValid presented during that time have no effect on the pending result.
- R7: Once set, outValid and outWord hold their values until the next accepted input.
- R8: outDone is high for exactly the cycle in which a new result first appears, and only together with outValid.
- R9: A synchronous active-high reset leaves outValid = 0, outDone = 0 and inReady = 1, abandoning any normalization in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input word is offered |
| inWord | input | 32 | Single-precision input word |
| inReady | output | 1 | Block is idle and will accept an offered word |
| outValid | output | 1 | outWord holds a converted result |
| outWord | output | 64 | Double-precision result image |
| outDone | output | 1 | One-cycle strobe marking a new result |

## Verification
Completing a subnormal's last shift and accepting the next word can fall in adjacent cycles. A producer that keeps inValid high throughout then presents a new word in the same cycle in which the final subnormal result first appears. The bench provokes this by changing inWord to a normal value while the subnormal is still shifting, with inValid held high. It then checks that the word shown after completion is the subnormal's result with inReady reasserted, and that the next edge replaces it with the normal result and a fresh done strobe. Every vector is also judged against an exponent and fraction computed arithmetically from its fields, over all 254 normal exponents and every subnormal leading-bit position.

// File: rtl/sgl2dbl_pkg.sv
package sgl2dbl_pkg;
  localparam int SGL_W      = 32;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRAC_W = SGL_W - SGL_EXP_W - 1;
  localparam int DBL_W      = 64;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_FRAC_W = DBL_W - DBL_EXP_W - 1;
  localparam int FILL_W     = DBL_EXP_W - SGL_EXP_W;
  localparam int PAD_W      = DBL_FRAC_W - SGL_FRAC_W;
  localparam int WEXP_W     = DBL_EXP_W + 1;
  localparam int SGL_BIAS   = (1 << (SGL_EXP_W - 1)) - 1;
  localparam int DBL_BIAS   = (1 << (DBL_EXP_W - 1)) - 1;
  localparam int MAX_SHIFT  = SGL_FRAC_W;
  localparam int CNT_W      = $clog2(MAX_SHIFT + 1);

  typedef struct packed {
    logic takeDirect;
    logic takeSub;
    logic shift;
    logic finish;
  } ctrlStrb_t;
endpackage

// File: rtl/sgl2dbl_classify.sv
module sgl2dbl_classify
  import sgl2dbl_pkg::*;
(
  input  logic [SGL_W-1:0] word,
  output logic             isSub,
  output logic [DBL_W-1:0] directImg
);
  logic [SGL_EXP_W-1:0]  expField;
  logic [SGL_FRAC_W-1:0] frac;
  logic                  isSpecial;
  logic                  topExp;
  logic [FILL_W-1:0]     fill;

  always_comb begin
    expField  = word[SGL_W-2 -: SGL_EXP_W];
    frac      = word[SGL_FRAC_W-1:0];
    topExp    = word[SGL_W-2];
    isSpecial = (expField == '1) || (word[SGL_W-2:0] == '0);
    isSub     = (expField == '0) && (frac != '0);
    fill      = isSpecial ? {FILL_W{topExp}} : {FILL_W{~topExp}};
    directImg = {word[SGL_W-1 -: 2], fill, word[SGL_W-3:0], {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/sgl2dbl_ctrl.sv
module sgl2dbl_ctrl
  import sgl2dbl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  input  logic      isSub,
  input  logic      leadOne,
  output logic      inReady,
  output ctrlStrb_t strb
);
  typedef enum logic {IDLE, NORMALIZE} state_t;
  state_t           state;
  logic             accept;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    inReady         = (state == IDLE);
    accept          = inValid && inReady;
    strb.takeDirect = accept && !isSub;
    strb.takeSub    = accept && isSub;
    strb.shift      = (state == NORMALIZE);
    strb.finish     = strb.shift && leadOne;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= IDLE;
      stepCnt <= '0;
    end else begin
      if (strb.takeSub) state <= NORMALIZE;
      else if (strb.finish) state <= IDLE;
      if (strb.shift) stepCnt <= stepCnt + CNT_W'(1);
      else stepCnt <= '0;
    end
  end

  // R5
  shift_bound_chk: assert property (@(posedge clk) disable iff (rst)
    strb.shift |-> (stepCnt < CNT_W'(MAX_SHIFT)));

  // R6
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
    strb.takeSub |=> !inReady);
endmodule

// File: rtl/sgl2dbl_dpath.sv
module sgl2dbl_dpath
  import sgl2dbl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  ctrlStrb_t             strb,
  input  logic                  inSign,
  input  logic [SGL_FRAC_W-1:0] inFrac,
  input  logic [DBL_W-1:0]      directImg,
  output logic                  leadOne,
  output logic                  outValid,
  output logic                  outDone,
  output logic [DBL_W-1:0]      outWord
);
  logic [DBL_FRAC_W-1:0] work;
  logic [DBL_FRAC_W-1:0] workNext;
  logic [WEXP_W-1:0]     wexp;
  logic [WEXP_W-1:0]     expNext;
  logic [WEXP_W-1:0]     biasedWide;
  logic [DBL_EXP_W-1:0]  biased;
  logic                  sgn;

  always_comb begin
    leadOne    = work[DBL_FRAC_W-1];
    workNext   = {work[DBL_FRAC_W-2:0], 1'b0};
    expNext    = wexp - WEXP_W'(1);
    biasedWide = expNext + WEXP_W'(DBL_BIAS);
    biased     = biasedWide[DBL_EXP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outDone  <= 1'b0;
      outWord  <= '0;
      work     <= '0;
      wexp     <= '0;
      sgn      <= 1'b0;
    end else begin
      outDone <= 1'b0;
      if (strb.takeDirect) begin
        outWord  <= directImg;
        outValid <= 1'b1;
        outDone  <= 1'b1;
      end
      if (strb.takeSub) begin
        work     <= {inFrac, {PAD_W{1'b0}}};
        wexp     <= WEXP_W'(1 - SGL_BIAS);
        sgn      <= inSign;
        outValid <= 1'b0;
      end
      if (strb.shift) begin
        work <= workNext;
        wexp <= expNext;
      end
      if (strb.finish) begin
        outWord  <= {sgn, biased, workNext};
        outValid <= 1'b1;
        outDone  <= 1'b1;
      end
    end
  end

  // R4
  direct_result_chk: assert property (@(posedge clk) disable iff (rst)
    strb.takeDirect |=> (outDone && outValid && outWord == $past(directImg)));

  // R6
  sub_drops_valid_chk: assert property (@(posedge clk) disable iff (rst)
    strb.takeSub |=> !outValid);

  // R3
  sub_exp_range_chk: assert property (@(posedge clk) disable iff (rst)
    strb.finish |=> (outWord[DBL_W-2 -: DBL_EXP_W] <= DBL_EXP_W'(DBL_BIAS - SGL_BIAS)));

  // R8
  done_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    outDone |-> outValid);
endmodule

// File: rtl/sgl2dbl_conv.sv
module sgl2dbl_conv
  import sgl2dbl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [SGL_W-1:0] inWord,
  output logic             inReady,
  output logic             outValid,
  output logic [DBL_W-1:0] outWord,
  output logic             outDone
);
  logic             isSub;
  logic             leadOne;
  logic [DBL_W-1:0] directImg;
  ctrlStrb_t        strb;

  sgl2dbl_classify i_classify (
    .word      (inWord),
    .isSub     (isSub),
    .directImg (directImg)
  );

  sgl2dbl_ctrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .isSub   (isSub),
    .leadOne (leadOne),
    .inReady (inReady),
    .strb    (strb)
  );

  sgl2dbl_dpath i_dpath (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .inSign    (inWord[SGL_W-1]),
    .inFrac    (inWord[SGL_FRAC_W-1:0]),
    .directImg (directImg),
    .leadOne   (leadOne),
    .outValid  (outValid),
    .outDone   (outDone),
    .outWord   (outWord)
  );

  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !(inValid && inReady)) |=> (outValid && $stable(outWord)));
endmodule

// File: tb/test_sgl2dbl_conv.sv
module test_sgl2dbl_conv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] inWord = '0;
  logic        inReady;
  logic        outValid;
  logic [63:0] outWord;
  logic        outDone;

  int vectors = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sgl2dbl_conv i_sgl2dbl_conv (
    .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord),
    .inReady(inReady), .outValid(outValid), .outWord(outWord), .outDone(outDone)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int leadPos(input logic [22:0] f);
    int p = 22;
    while (p > 0 && !f[p]) p--;
    return p;
  endfunction

  function automatic logic [63:0] expectOf(input logic [31:0] w);
    logic s = w[31];
    int e = int'(w[30:23]);
    logic [22:0] f = w[22:0];
    if (e == 255) return {s, 11'h7FF, f, 29'b0};
    if (e == 0 && f == 0) return {s, 11'd0, 52'd0};
    if (e == 0) begin
      int p = leadPos(f);
      int k = 23 - p;
      logic [51:0] m = (52'(f) & ~(52'd1 << p)) << (52 - p);
      return {s, 11'(897 - k), m};
    end
    return {s, 11'(e + 896), f, 29'b0};
  endfunction

  function automatic int latencyOf(input logic [31:0] w);
    if (w[30:23] == 8'd0 && w[22:0] != 23'd0) return 23 - leadPos(w[22:0]) + 1;
    return 1;
  endfunction

  function automatic string reqOf(input logic [31:0] w);
    if (w[30:23] == 8'hFF || w[30:0] == 31'd0) return "R2";
    if (w[30:23] == 8'd0) return "R3";
    return "R1";
  endfunction

  task automatic apply(input logic [31:0] w);
    int lat = 0;
    bit sub = (w[30:23] == 8'd0 && w[22:0] != 23'd0);
    @(negedge clk);
    inWord = w;
    inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    #1 inValid = 1'b0;
    do begin
      @(negedge clk);
      lat++;
      if (!outValid) chk(!inReady, "R6 ready low while normalizing", 64'(inReady), 64'd0);
    end while (!outValid && lat < 40);
    chk(outWord == expectOf(w), reqOf(w), outWord, expectOf(w));
    chk(outDone, "R8 done with new result", 64'(outDone), 64'd1);
    chk(lat == latencyOf(w), sub ? "R5 latency" : "R4 latency", 64'(lat), 64'(latencyOf(w)));
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!outValid && !outDone && inReady, "R9 reset state",
        {61'd0, outValid, outDone, inReady}, 64'd1);
    rst = 1'b0;

    // R1 sweep of all normal exponents
    for (int e = 1; e <= 254; e++) begin
      apply({1'b0, 8'(e), 23'd0});
      apply({1'b1, 8'(e), 23'h7FFFFF});
      apply({1'(e), 8'(e), 23'h2AAAAA ^ 23'(e * 977)});
    end

    // R2 specials
    apply(32'h0000_0000);
    apply(32'h8000_0000);
    apply(32'h7F80_0000);
    apply(32'hFF80_0000);
    apply(32'h7FC0_0001);
    apply(32'hFFFF_FFFF);
    apply(32'h7F80_0001);

    // R3 every leading-bit position of a subnormal
    for (int p = 0; p < 23; p++) begin
      logic [22:0] b = 23'd1 << p;
      apply({1'b0, 8'd0, b});
      apply({1'b1, 8'd0, b | (b - 23'd1)});
      apply({1'(p), 8'd0, b | (23'h155555 & (b - 23'd1))});
    end

    // R7 result held without new input
    apply(32'h3FC0_0000);
    repeat (3) @(negedge clk);
    chk(outValid && !outDone && outWord == expectOf(32'h3FC0_0000), "R7 hold",
        outWord, expectOf(32'h3FC0_0000));

    // R6 input held during normalization, new word offered before completion
    @(negedge clk);
    w = 32'h0000_0001;
    inWord = w;
    inValid = 1'b1;
    @(posedge clk);
    #1 inWord = 32'h4049_0FDB;
    begin
      int lat = 0;
      do begin
        @(negedge clk);
        lat++;
      end while (!outValid && lat < 40);
      chk(outWord == expectOf(w), "R6 pending result unaffected", outWord, expectOf(w));
      chk(lat == 24, "R5 worst-case latency", 64'(lat), 64'd24);
      chk(inReady, "R6 ready back after result", 64'(inReady), 64'd1);
    end
    @(negedge clk);
    inValid = 1'b0;
    chk(outWord == expectOf(32'h4049_0FDB) && outDone, "R8 next result strobed",
        outWord, expectOf(32'h4049_0FDB));

    // R9 reset during normalization
    @(negedge clk);
    inWord = 32'h8000_0002;
    inValid = 1'b1;
    @(posedge clk);
    #1 inValid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!outValid && !outDone && inReady, "R9 reset abandons shift",
        {61'd0, outValid, outDone, inReady}, 64'd1);
    apply(32'h3F80_0000);

    summary();
    $finish;
  end
endmodule